// File: doc/BRIEF.md
# Serial EEPROM Status Register with Polled Readback

This block is the status register of a small serial EEPROM slave, together with the logic that answers its read-status command. It holds four meaningful flags: a busy flag for an internal write cycle, a latch that arms writes, and two block-protect bits. The upstream command decoder hands it one-cycle strobes for arm, disarm, status-write (with a data byte) and status-read. The memory array reports its own write activity on a busy line.

A status read returns one byte, one bit per shift strobe, most significant bit first. After the eighth bit the block waits for the master's acknowledge. A continue answer reloads the byte from the live register state and sends it again. A stop answer ends the command. A master can therefore poll the busy flag for as long as it needs without reissuing the command. Writing the status register starts a self-timed internal cycle of `WR_CYCLES` clocks. The new protect bits are visible from the moment the write is accepted. The protect bits keep their value across reset, which stands in for nonvolatile storage.

Top module: `eep_status_unit`

## Requirements
- R1: The status byte carries the busy flag in bit 0, the write latch in bit 1, protect bit 0 in bit 2 and protect bit 1 in bit 3.
- R2: Bits 7 to 4 of every status byte read as 0, whatever was written.
- R3: The busy flag is 1 for `WR_CYCLES` clocks after an accepted status write, and whenever `array_busy` is 1.
- R4: `cmd_wren` sets the write latch and `cmd_wrdi` clears it. When both arrive in the same cycle, clearing wins. Nothing else sets the latch.
- R5: The protect bits change only through an accepted status write, which loads `wrsr_data[3:2]` into them. They keep their value through reset.
- R6: A status write is ignored while the write latch is 0 or the busy flag is 1.
- R7: `cmd_wren` is ignored while the busy flag is 1.
- R8: A status byte is shifted out MSB first, one bit per `bit_adv`, and is captured from the register state in the cycle its transfer starts. That cycle is either the `cmd_rdsr` cycle or the continue cycle. After 8 bits `ack_wait` is 1. An `ack_strobe` with `ack_mak`=1 starts a new byte that holds the current flags.
- R9: An `ack_strobe` with `ack_mak`=0 ends the command, and `tx_active` returns to 0.
- R10: The write latch is cleared when a self-timed status write cycle ends, and when `array_busy` falls.
- R11: A read started while a status write cycle is running returns the newly written protect bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (protect bits excepted) |
| cmd_wren | input | 1 | Arm-write command strobe |
| cmd_wrdi | input | 1 | Disarm-write command strobe |
| cmd_wrsr | input | 1 | Status-write command strobe |
| wrsr_data | input | 8 | Data byte for the status write; bits 3:2 used |
| cmd_rdsr | input | 1 | Status-read command strobe |
| array_busy | input | 1 | Memory array write cycle running |
| bit_adv | input | 1 | Advance to the next output bit |
| ack_strobe | input | 1 | Master acknowledge slot is valid |
| ack_mak | input | 1 | 1 = send again, 0 = stop |
| tx_bit | output | 1 | Current output bit |
| tx_active | output | 1 | A read-status command is in progress |
| ack_wait | output | 1 | Byte finished, waiting for acknowledge |

## Verification
A byte reload on a continue acknowledge can fall in the same clock as a write-latch update. That update may be a disarm command or the end of a write cycle. The bench drives `ack_mak`=1 with `cmd_wrdi` in the same cycle. It expects the reloaded byte to show the latch as it stood before that edge, and the following repeat to show it cleared. A second collision pairs a status write with an immediately following read. There the first byte must show busy=1 and the new protect bits, and the repeat must show busy and latch both back at 0.

// File: rtl/eep_status_pkg.sv
package eep_status_pkg;
   localparam int STS_W    = 8;
   localparam int POS_BUSY = 0;
   localparam int POS_WEN  = 1;
   localparam int POS_PR0  = 2;
   localparam int POS_PR1  = 3;
   localparam int PR_W     = 2;

   typedef enum logic [1:0] {
      SH_IDLE  = 2'd0,
      SH_SHIFT = 2'd1,
      SH_ACK   = 2'd2
   } sh_state_t;

   function automatic logic [STS_W-1:0] pack_status(
      input logic busy, input logic wen, input logic [PR_W-1:0] pr);
      logic [STS_W-1:0] v;
      v = '0;
      v[POS_BUSY] = busy;
      v[POS_WEN]  = wen;
      v[POS_PR0]  = pr[0];
      v[POS_PR1]  = pr[1];
      return v;
   endfunction
endpackage

// File: rtl/eep_wcycle_timer.sv
module eep_wcycle_timer #(
   parameter int CYCLES = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int CW = $clog2(CYCLES + 1);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt_q <= '0;
      else if (start)      cnt_q <= CW'(CYCLES);
      else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);
   assign done = (cnt_q == CW'(1));
endmodule

// File: rtl/eep_status_regs.sv
module eep_status_regs
   import eep_status_pkg::*;
#(
   parameter int            WR_CYCLES = 200,
   parameter bit            KEEP_PR   = 1'b1,
   parameter logic [PR_W-1:0] PR_INIT = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_wren,
   input  logic            cmd_wrdi,
   input  logic            cmd_wrsr,
   input  logic [PR_W-1:0] wr_pr,
   input  logic            array_busy,
   output logic            busy,
   output logic            wen,
   output logic [PR_W-1:0] pr
);
   logic tmr_busy, tmr_done, wrsr_ok, arr_q, arr_done, wen_q;

   assign busy    = tmr_busy | array_busy;
   assign wrsr_ok = cmd_wrsr & wen_q & ~busy;

   eep_wcycle_timer #(.CYCLES(WR_CYCLES)) u_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .start(wrsr_ok),
      .busy (tmr_busy),
      .done (tmr_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) arr_q <= 1'b0;
      else        arr_q <= array_busy;
   end
   assign arr_done = arr_q & ~array_busy;

   always_ff @(posedge clk) begin
      if (!rst_n)                              wen_q <= 1'b0;
      else if (cmd_wrdi | tmr_done | arr_done) wen_q <= 1'b0;
      else if (cmd_wren & ~busy)               wen_q <= 1'b1;
   end
   assign wen = wen_q;

   generate
      if (KEEP_PR) begin : g_keep
         logic [PR_W-1:0] pr_q = PR_INIT;
         always_ff @(posedge clk) begin
            if (wrsr_ok) pr_q <= wr_pr;
         end
         assign pr = pr_q;
      end else begin : g_reset
         logic [PR_W-1:0] pr_q;
         always_ff @(posedge clk) begin
            if (!rst_n)       pr_q <= PR_INIT;
            else if (wrsr_ok) pr_q <= wr_pr;
         end
         assign pr = pr_q;
      end
   endgenerate
endmodule

// File: rtl/eep_status_shifter.sv
module eep_status_shifter
   import eep_status_pkg::*;
#(
   parameter int W = STS_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rd_start,
   input  logic [W-1:0] live_byte,
   input  logic         bit_adv,
   input  logic         ack_strobe,
   input  logic         ack_mak,
   output logic         tx_bit,
   output logic         tx_active,
   output logic         ack_wait
);
   localparam int CW = $clog2(W);
   sh_state_t     st_q;
   logic [W-1:0]  sreg_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= SH_IDLE;
         sreg_q <= '0;
         cnt_q  <= '0;
      end else begin
         unique case (st_q)
            SH_IDLE: if (rd_start) begin
               st_q   <= SH_SHIFT;
               sreg_q <= live_byte;
               cnt_q  <= '0;
            end
            SH_SHIFT: if (bit_adv) begin
               sreg_q <= {sreg_q[W-2:0], 1'b0};
               if (cnt_q == CW'(W - 1)) begin
                  st_q  <= SH_ACK;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            SH_ACK: if (ack_strobe) begin
               if (ack_mak) begin
                  st_q   <= SH_SHIFT;
                  sreg_q <= live_byte;
               end else begin
                  st_q <= SH_IDLE;
               end
            end
            default: st_q <= SH_IDLE;
         endcase
      end
   end

   assign tx_bit    = (st_q == SH_SHIFT) & sreg_q[W-1];
   assign tx_active = (st_q != SH_IDLE);
   assign ack_wait  = (st_q == SH_ACK);
endmodule

// File: rtl/eep_status_unit.sv
module eep_status_unit
   import eep_status_pkg::*;
#(
   parameter int              WR_CYCLES = 200,
   parameter bit              KEEP_PR   = 1'b1,
   parameter logic [PR_W-1:0] PR_INIT   = '0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_wren,
   input  logic       cmd_wrdi,
   input  logic       cmd_wrsr,
   input  logic [7:0] wrsr_data,
   input  logic       cmd_rdsr,
   input  logic       array_busy,
   input  logic       bit_adv,
   input  logic       ack_strobe,
   input  logic       ack_mak,
   output logic       tx_bit,
   output logic       tx_active,
   output logic       ack_wait
);
   generate
      if (WR_CYCLES < 1) begin : g_bad_cycles
         $error("WR_CYCLES must be at least 1");
      end
      if (STS_W != 8) begin : g_bad_width
         $error("status byte must be 8 bits");
      end
   endgenerate

   logic            wip, wel;
   logic [PR_W-1:0] bp;
   logic [STS_W-1:0] status_now;
   logic             unused_hi;

   assign unused_hi = ^{wrsr_data[7:4], wrsr_data[1:0]};

   eep_status_regs #(
      .WR_CYCLES(WR_CYCLES),
      .KEEP_PR  (KEEP_PR),
      .PR_INIT  (PR_INIT)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_wren  (cmd_wren),
      .cmd_wrdi  (cmd_wrdi),
      .cmd_wrsr  (cmd_wrsr),
      .wr_pr     (wrsr_data[POS_PR1:POS_PR0]),
      .array_busy(array_busy),
      .busy      (wip),
      .wen       (wel),
      .pr        (bp)
   );

   assign status_now = pack_status(wip, wel, bp);

   eep_status_shifter #(.W(STS_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_start  (cmd_rdsr),
      .live_byte (status_now),
      .bit_adv   (bit_adv),
      .ack_strobe(ack_strobe),
      .ack_mak   (ack_mak),
      .tx_bit    (tx_bit),
      .tx_active (tx_active),
      .ack_wait  (ack_wait)
   );
endmodule

// File: rtl/eep_status_chk.sv
module eep_status_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_wren,
   input logic       cmd_wrdi,
   input logic       cmd_wrsr,
   input logic       array_busy,
   input logic       bit_adv,
   input logic       ack_strobe,
   input logic       ack_mak,
   input logic       tx_bit,
   input logic       tx_active,
   input logic       ack_wait,
   input logic       wip,
   input logic       wel,
   input logic [1:0] bp
);
   logic [3:0] bits_seen;
   logic       shifting;

   assign shifting = tx_active & ~ack_wait;

   always_ff @(posedge clk) begin
      if (!rst_n || !shifting) bits_seen <= '0;
      else if (bit_adv)        bits_seen <= bits_seen + 1'b1;
   end

   assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (shifting && bits_seen < 4'd4) |-> !tx_bit);

   assert_array_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      array_busy |-> wip);

   assert_wel_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel) |-> $past(cmd_wren && !cmd_wrdi && !wip));

   assert_wrdi_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wrdi |=> !wel);

   assert_bp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_wrsr |=> $stable(bp));

   assert_wrsr_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wrsr && (!wel || wip)) |=> $stable(bp));

   assert_wren_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wren && wip && !wel) |=> !wel);

   assert_mak_repeat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wait && ack_strobe && ack_mak) |=> (tx_active && !ack_wait));

   assert_nomak_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wait && ack_strobe && !ack_mak) |=> !tx_active);

   assert_array_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!array_busy && $past(array_busy)) |=> !wel);
endmodule

bind eep_status_unit eep_status_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_wren  (cmd_wren),
   .cmd_wrdi  (cmd_wrdi),
   .cmd_wrsr  (cmd_wrsr),
   .array_busy(array_busy),
   .bit_adv   (bit_adv),
   .ack_strobe(ack_strobe),
   .ack_mak   (ack_mak),
   .tx_bit    (tx_bit),
   .tx_active (tx_active),
   .ack_wait  (ack_wait),
   .wip       (wip),
   .wel       (wel),
   .bp        (bp)
);

// File: tb/eep_status_unit_test.sv
module eep_status_unit_test;
   localparam int WRC = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_rdsr = 0;
   logic [7:0] wrsr_data = '0;
   logic       array_busy = 0, bit_adv = 0, ack_strobe = 0, ack_mak = 0;
   logic       tx_bit, tx_active, ack_wait;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   eep_status_unit #(.WR_CYCLES(WRC)) uut (
      .clk(clk), .rst_n(rst_n),
      .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
      .wrsr_data(wrsr_data), .cmd_rdsr(cmd_rdsr), .array_busy(array_busy),
      .bit_adv(bit_adv), .ack_strobe(ack_strobe), .ack_mak(ack_mak),
      .tx_bit(tx_bit), .tx_active(tx_active), .ack_wait(ack_wait)
   );

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wren();
      cmd_wren = 1; @(negedge clk); cmd_wren = 0;
   endtask

   task automatic wrdi();
      cmd_wrdi = 1; @(negedge clk); cmd_wrdi = 0;
   endtask

   task automatic wrsr(input logic [7:0] d);
      cmd_wrsr = 1; wrsr_data = d; @(negedge clk); cmd_wrsr = 0;
   endtask

   task automatic start_rd();
      cmd_rdsr = 1; @(negedge clk); cmd_rdsr = 0;
   endtask

   task automatic shift_byte(output logic [7:0] b);
      for (int i = 0; i < 8; i++) begin
         b[7-i] = tx_bit;
         bit_adv = 1; @(negedge clk);
      end
      bit_adv = 0;
   endtask

   task automatic give_ack(input logic mak);
      ack_strobe = 1; ack_mak = mak; @(negedge clk);
      ack_strobe = 0; ack_mak = 0;
   endtask

   task automatic read_once(output logic [7:0] b);
      start_rd();
      shift_byte(b);
      give_ack(1'b0);
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL R9: watchdog expired, actual hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] b;
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      check({7'b0, tx_active}, 8'h00, "R9 reset idle");
      check({7'b0, ack_wait}, 8'h00, "R8 reset no ack wait");

      read_once(b);
      check(b, 8'h00, "R1 initial status");
      check({7'b0, tx_active}, 8'h00, "R9 nomak ends");

      // R6: status write with latch clear is ignored
      wrsr(8'h0C); idle(2);
      read_once(b);
      check(b, 8'h00, "R6 wrsr without latch");

      // R4: set, clear, simultaneous
      wren(); read_once(b);
      check(b, 8'h02, "R4 wren sets latch R1 bit1");
      wrdi(); read_once(b);
      check(b, 8'h00, "R4 wrdi clears latch");
      cmd_wren = 1; cmd_wrdi = 1; @(negedge clk); cmd_wren = 0; cmd_wrdi = 0;
      read_once(b);
      check(b, 8'h00, "R4 wrdi wins over wren");

      // R3 R11 R8 R10 R2: write then poll
      wren(); wrsr(8'hFF);
      start_rd();
      shift_byte(b);
      check({7'b0, ack_wait}, 8'h01, "R8 ack wait after 8 bits");
      check(b, 8'h0F, "R11 R3 busy with new protect, R2 upper zero");
      give_ack(1'b1);
      check({7'b0, tx_active}, 8'h01, "R8 mak keeps command");
      shift_byte(b);
      check(b, 8'h0C, "R10 R8 live repeat after cycle end");
      give_ack(1'b0);
      check({7'b0, tx_active}, 8'h00, "R9 nomak ends");

      // R6: status write while busy is ignored
      wren();
      wrsr(8'h00);
      wrsr(8'h08);
      idle(WRC + 2);
      read_once(b);
      check(b, 8'h00, "R6 wrsr during busy ignored");

      // R7: wren during array busy ignored; R3 busy from array
      array_busy = 1; @(negedge clk);
      wren();
      read_once(b);
      check(b, 8'h01, "R7 wren ignored R3 array busy");
      array_busy = 0; @(negedge clk);
      wren();
      array_busy = 1; idle(3); array_busy = 0; idle(2);
      read_once(b);
      check(b, 8'h00, "R10 array write end clears latch");

      // R5 across reset
      wren(); wrsr(8'h04); idle(WRC + 2);
      rst_n = 0; idle(2); rst_n = 1; @(negedge clk);
      read_once(b);
      check(b, 8'h04, "R5 protect kept through reset");

      // Collision: mak reload together with wrdi
      wren();
      start_rd();
      shift_byte(b);
      check(b, 8'h06, "R8 byte before collision");
      ack_strobe = 1; ack_mak = 1; cmd_wrdi = 1; @(negedge clk);
      ack_strobe = 0; ack_mak = 0; cmd_wrdi = 0;
      shift_byte(b);
      check(b, 8'h06, "R8 reload captures pre-edge latch");
      give_ack(1'b1);
      shift_byte(b);
      check(b, 8'h04, "R4 R8 repeat shows cleared latch");
      give_ack(1'b0);

      // Sweep of all protect values with varying ignored bits
      for (int v = 0; v < 4; v++) begin
         logic [7:0] d;
         d = {4'(v * 5 + 3), v[1:0], 2'(v + 1)};
         wren(); wrsr(d);
         read_once(b);
         check(b, {4'h0, v[1:0], 2'b11}, "R11 R2 sweep during cycle");
         idle(WRC);
         read_once(b);
         check(b, {4'h0, v[1:0], 2'b00}, "R5 R10 sweep after cycle");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule